// File: doc/BRIEF.md
# UART Receiver with Break Wake-up

This block receives asynchronous serial words on one input line and holds them until software collects them. The line is resynchronized, and each bit is sampled at its middle using a tick that runs at sixteen times the bit rate. Each word goes into a two-entry holding buffer. The receive-interrupt output stays high while any word is waiting. A read strobe removes the head entry. The head entry's data, ninth bit and framing status are always visible on the outputs.

Software can place the receiver in a wake-up watch mode. In this mode ordinary reception is suspended, and the block only waits for the line to fall. That falling edge marks the start of a break or wake-up character. It raises the receive interrupt. The next rising edge ends the mode without any software action, and normal reception resumes.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, rx_irq, overrun, frame_err, rd_bit9 and wake_en are 0, and rd_data reads 0.
- R2: A frame has these parts in order: a low start bit, eight data bits with the least significant bit first, and a high stop bit. A received word appears on rd_data, and rx_irq is 1 while the buffer holds at least one word.
- R3: When nine_bit is 1, one extra data bit follows the eighth data bit. It is reported on rd_bit9. When nine_bit is 0, rd_bit9 reads 0.
- R4: frame_err is 1 when the head word's stop bit was sampled low. It is 0 for a word with a high stop bit.
- R5: A start bit that is no longer low at its midpoint (8 ticks after detection) is discarded and produces no word.
- R6: The buffer holds two words, read out in arrival order. A one-cycle pulse on rd_stb removes the head word.
- R7: When a word completes while both entries are unread, that word is lost and overrun becomes 1. While overrun is 1, every completed word is discarded. Overrun returns to 0 only while rx_en is 0.
- R8: While rx_en is 0, no word is received.
- R9: A pulse on wake_set sets wake_en. While wake_en is 1, no word is received.
- R10: While wake_en is 1 and no falling edge has yet been seen, a falling edge on the line sets rx_irq. A read strobe clears that interrupt.
- R11: After the falling edge, wake_en clears itself on the next rising edge of the line, and normal reception then works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high, asynchronous |
| rx_en | input | 1 | Receive enable; a low level also clears overrun |
| nine_bit | input | 1 | Selects 9 data bits per frame |
| wake_set | input | 1 | Pulse that sets the wake-up watch bit |
| rd_stb | input | 1 | Read strobe; pops the head word and clears the wake interrupt |
| rd_data | output | 8 | Data of the head word, 0 when empty |
| rd_bit9 | output | 1 | Ninth bit of the head word |
| rx_irq | output | 1 | Receive interrupt |
| frame_err | output | 1 | Stop bit of the head word was low |
| overrun | output | 1 | A word was lost to a full buffer |
| wake_en | output | 1 | Wake-up watch mode active |

## Verification
The assertions assume the following about the inputs. baud_tick is a one-cycle pulse, spaced several clocks apart. rd_stb and wake_set are single-cycle pulses. rx_in holds each bit for sixteen ticks, so the edges seen by the wake logic and the midpoint samples come from settled levels. The stimulus derives every line transition from one fixed bit period of 64 clocks, driven at falling clock edges. It gives each frame a full idle bit after its stop bit. It toggles rx_en only while the line is idle, so no frame is cut short by the enable or by entry into wake mode.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              b9;
        logic              ferr;
    } uwr_word_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_NINTH,
        FR_STOP
    } fr_state_e;

    typedef enum logic {
        WK_ARMED,
        WK_SEEN
    } wk_phase_e;
endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/uwr_frame.sv
module uwr_frame
    import uwr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxs,
    input  logic      en,
    input  logic      nine_en,
    output logic      done,
    output uwr_word_t word
);
    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DATA_W);
    localparam int MID  = OSR / 2 - 1;
    localparam int LAST = OSR - 1;

    typedef struct packed {
        fr_state_e         st;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     bitn;
        logic [DATA_W-1:0] sh;
        logic              b9;
    } fr_reg_t;

    fr_reg_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        word = '{data: r_q.sh, b9: r_q.b9, ferr: ~rxs};
        if (!en) begin
            r_d.st  = FR_IDLE;
            r_d.cnt = '0;
        end else if (tick) begin
            case (r_q.st)
                FR_IDLE: begin
                    if (!rxs) begin
                        r_d.st  = FR_START;
                        r_d.cnt = '0;
                    end
                end
                FR_START: begin
                    if (r_q.cnt == CW'(MID)) begin
                        r_d.cnt  = '0;
                        r_d.bitn = '0;
                        r_d.b9   = 1'b0;
                        r_d.st   = rxs ? FR_IDLE : FR_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                FR_DATA: begin
                    if (r_q.cnt == CW'(LAST)) begin
                        r_d.cnt = '0;
                        r_d.sh  = {rxs, r_q.sh[DATA_W-1:1]};
                        if (r_q.bitn == BW'(DATA_W - 1))
                            r_d.st = nine_en ? FR_NINTH : FR_STOP;
                        else
                            r_d.bitn = r_q.bitn + BW'(1);
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                FR_NINTH: begin
                    if (r_q.cnt == CW'(LAST)) begin
                        r_d.cnt = '0;
                        r_d.b9  = rxs;
                        r_d.st  = FR_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                FR_STOP: begin
                    if (r_q.cnt == CW'(LAST)) begin
                        done    = 1'b1;
                        r_d.cnt = '0;
                        r_d.st  = FR_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                default: r_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: FR_IDLE, cnt: '0, bitn: '0, sh: '0, b9: 1'b0};
        else        r_q <= r_d;
    end

    // R5: a sample at the start midpoint that finds the line high returns to idle
    a_r5_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && r_q.st == FR_START && r_q.cnt == CW'(MID) && rxs) |=> r_q.st == FR_IDLE);

    // R2: a word completes only from the stop state
    a_r2_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_q.st == FR_STOP && en && tick));
endmodule

// File: rtl/uwr_hold.sv
module uwr_hold
    import uwr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  uwr_word_t wdata,
    input  logic      pop,
    output uwr_word_t head,
    output logic      empty,
    output logic      full
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        uwr_word_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CNTW-1:0]       cnt;
    } hold_reg_t;

    hold_reg_t h_d, h_q;
    logic do_pop, do_push;

    always_comb begin
        h_d     = h_q;
        do_pop  = pop && (h_q.cnt != '0);
        do_push = push && ((h_q.cnt != CNTW'(DEPTH)) || do_pop);
        if (do_push) begin
            h_d.mem[h_q.wp] = wdata;
            h_d.wp = (h_q.wp == PW'(DEPTH - 1)) ? '0 : h_q.wp + PW'(1);
        end
        if (do_pop)
            h_d.rp = (h_q.rp == PW'(DEPTH - 1)) ? '0 : h_q.rp + PW'(1);
        if (do_push && !do_pop)      h_d.cnt = h_q.cnt + CNTW'(1);
        else if (do_pop && !do_push) h_d.cnt = h_q.cnt - CNTW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign head  = h_q.mem[h_q.rp];
    assign empty = (h_q.cnt == '0);
    assign full  = (h_q.cnt == CNTW'(DEPTH));

    // R6: occupancy never exceeds the buffer depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.cnt <= CNTW'(DEPTH));

    // R7: the owner never offers a word to a full buffer without popping
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uwr_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rx_in,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              wake_set,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rx_irq,
    output logic              frame_err,
    output logic              overrun,
    output logic              wake_en
);
    typedef struct packed {
        logic      wake_en;
        wk_phase_e phase;
        logic      wake_flag;
        logic      ovr;
        logic      rx_prev;
    } top_reg_t;

    top_reg_t  t_d, t_q;
    logic      rxs, fall, rise;
    logic      fr_done, fr_en;
    uwr_word_t fr_word, head;
    logic      buf_empty, buf_full, buf_push, word_ok;

    uwr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rxs)
    );

    assign fr_en = rx_en & ~t_q.wake_en;

    uwr_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxs(rxs),
        .en(fr_en), .nine_en(nine_bit), .done(fr_done), .word(fr_word)
    );

    uwr_hold #(.DEPTH(DEPTH)) u_hold (
        .clk(clk), .rst_n(rst_n), .push(buf_push), .wdata(fr_word),
        .pop(rd_stb), .head(head), .empty(buf_empty), .full(buf_full)
    );

    always_comb begin
        t_d      = t_q;
        fall     = t_q.rx_prev & ~rxs;
        rise     = ~t_q.rx_prev & rxs;
        word_ok  = fr_done && !t_q.ovr;
        buf_push = word_ok && (!buf_full || rd_stb);

        if (rd_stb) t_d.wake_flag = 1'b0;
        if (t_q.wake_en) begin
            if (t_q.phase == WK_ARMED && fall) begin
                t_d.wake_flag = 1'b1;
                t_d.phase     = WK_SEEN;
            end else if (t_q.phase == WK_SEEN && rise) begin
                t_d.wake_en = 1'b0;
            end
        end
        if (wake_set) begin
            t_d.wake_en = 1'b1;
            t_d.phase   = WK_ARMED;
        end

        if (word_ok && buf_full && !rd_stb) t_d.ovr = 1'b1;
        if (!rx_en) t_d.ovr = 1'b0;
        t_d.rx_prev = rxs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{wake_en: 1'b0, phase: WK_ARMED, wake_flag: 1'b0, ovr: 1'b0, rx_prev: 1'b1};
        else        t_q <= t_d;
    end

    assign rd_data   = buf_empty ? '0 : head.data;
    assign rd_bit9   = ~buf_empty & head.b9;
    assign frame_err = ~buf_empty & head.ferr;
    assign rx_irq    = ~buf_empty | t_q.wake_flag;
    assign overrun   = t_q.ovr;
    assign wake_en   = t_q.wake_en;

    // R7: overrun is sticky while reception stays enabled
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.ovr && rx_en) |=> t_q.ovr);

    // R7: a low enable clears overrun
    a_r7_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !t_q.ovr);

    // R9: the framer completes nothing once wake mode is settled
    a_r9_quiet_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(t_q.wake_en) && t_q.wake_en) |-> !fr_done);

    // R10: a falling edge while armed raises the interrupt
    a_r10_edge_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.wake_en && t_q.phase == WK_ARMED && fall && !wake_set) |=> rx_irq);

    // R11: the watch bit drops only after a rising line edge
    a_r11_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(t_q.wake_en) |-> ($past(rxs) && !$past(t_q.rx_prev)));
endmodule

// File: tb/tb_uart_wake_rx.sv
module tb_uart_wake_rx;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       wake_set = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rx_irq, frame_err, overrun, wake_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    uart_wake_rx dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
        .rx_en(rx_en), .nine_bit(nine_bit), .wake_set(wake_set), .rd_stb(rd_stb),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .rx_irq(rx_irq),
        .frame_err(frame_err), .overrun(overrun), .wake_en(wake_en)
    );

    always #10 clk = ~clk;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            baud_tick = (div == TICK_DIV - 1);
            div = (div == TICK_DIV - 1) ? 0 : div + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clocks);
        rx_in = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input bit use9, input logic stop_v);
        hold_line(1'b0, BIT_CLK);
        for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CLK);
        if (use9) hold_line(b9, BIT_CLK);
        hold_line(stop_v, BIT_CLK);
        hold_line(1'b1, BIT_CLK);
    endtask

    task automatic pop_word();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(rx_irq == 1'b0,    "R1 rx_irq",    rx_irq, 0);
        check(overrun == 1'b0,   "R1 overrun",   overrun, 0);
        check(wake_en == 1'b0,   "R1 wake_en",   wake_en, 0);
        check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        check(rd_data == 8'h00,  "R1 rd_data",   rd_data, 0);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
        check(rx_irq == 1'b1,    "R2 irq after word", rx_irq, 1);
        check(rd_data == 8'hA5,  "R2 data A5",        rd_data, 8'hA5);
        check(frame_err == 1'b0, "R4 clean stop",     frame_err, 0);
        check(rd_bit9 == 1'b0,   "R3 bit9 off",       rd_bit9, 0);
        pop_word();
        check(rx_irq == 1'b0,    "R6 irq after pop",  rx_irq, 0);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        check(rd_data == 8'h3C,  "R2 data 3C",        rd_data, 8'h3C);
        pop_word();
    endtask

    task automatic t_ninth();
        nine_bit = 1'b1;
        send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
        check(rd_data == 8'h5A, "R3 data 5A", rd_data, 8'h5A);
        check(rd_bit9 == 1'b1,  "R3 bit9 set", rd_bit9, 1);
        pop_word();
        send_frame(8'h81, 1'b0, 1'b1, 1'b1);
        check(rd_data == 8'h81, "R3 data 81", rd_data, 8'h81);
        check(rd_bit9 == 1'b0,  "R3 bit9 clear", rd_bit9, 0);
        pop_word();
        nine_bit = 1'b0;
    endtask

    task automatic t_ferr();
        send_frame(8'h0F, 1'b0, 1'b0, 1'b0);
        check(frame_err == 1'b1, "R4 low stop", frame_err, 1);
        check(rd_data == 8'h0F,  "R4 data 0F",  rd_data, 8'h0F);
        pop_word();
        check(rx_irq == 1'b0,    "R5 no extra word after low stop", rx_irq, 0);
    endtask

    task automatic t_glitch();
        hold_line(1'b0, 16);
        hold_line(1'b1, 12 * BIT_CLK);
        check(rx_irq == 1'b0, "R5 short pulse ignored", rx_irq, 0);
    endtask

    task automatic t_buffer();
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b0, 1'b1);
        check(overrun == 1'b0,  "R6 two words fit", overrun, 0);
        check(rd_data == 8'h11, "R6 head first",    rd_data, 8'h11);
        send_frame(8'h33, 1'b0, 1'b0, 1'b1);
        check(overrun == 1'b1,  "R7 third word overruns", overrun, 1);
        pop_word();
        check(rd_data == 8'h22, "R6 second in order", rd_data, 8'h22);
        pop_word();
        check(rx_irq == 1'b0,   "R7 third word lost", rx_irq, 0);
        send_frame(8'h44, 1'b0, 1'b0, 1'b1);
        check(rx_irq == 1'b0,   "R7 discard while overrun", rx_irq, 0);
        check(overrun == 1'b1,  "R7 overrun sticky", overrun, 1);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        check(overrun == 1'b0,  "R7 cleared by enable low", overrun, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(8'h55, 1'b0, 1'b0, 1'b1);
        check(rd_data == 8'h55, "R7 reception after clear", rd_data, 8'h55);
        pop_word();
    endtask

    task automatic t_gate();
        rx_en = 1'b0;
        send_frame(8'h66, 1'b0, 1'b0, 1'b1);
        check(rx_irq == 1'b0, "R8 disabled receives nothing", rx_irq, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_wake();
        @(negedge clk) wake_set = 1'b1;
        @(negedge clk) wake_set = 1'b0;
        check(wake_en == 1'b1, "R9 wake_en set", wake_en, 1);
        check(rx_irq == 1'b0,  "R10 no irq before edge", rx_irq, 0);
        hold_line(1'b0, 8);
        check(rx_irq == 1'b1,  "R10 irq on falling edge", rx_irq, 1);
        hold_line(1'b0, 13 * BIT_CLK);
        check(wake_en == 1'b1, "R11 held during low", wake_en, 1);
        pop_word();
        check(rx_irq == 1'b0,  "R10 read clears irq", rx_irq, 0);
        hold_line(1'b1, 8);
        check(wake_en == 1'b0, "R11 cleared on rise", wake_en, 0);
        check(rx_irq == 1'b0,  "R9 break gave no word", rx_irq, 0);
        hold_line(1'b1, BIT_CLK);
        send_frame(8'h77, 1'b0, 1'b0, 1'b1);
        check(rd_data == 8'h77, "R11 normal reception resumes", rd_data, 8'h77);
        pop_word();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        t_basic();
        t_ninth();
        t_ferr();
        t_glitch();
        t_buffer();
        t_gate();
        t_wake();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule